// File: doc/BRIEF.md
# Flash erase command sequencer

This block is the command front end of a parallel NOR flash for erase operations. It watches synchronous bus write cycles and recognises block-erase requests, either through the full six-write sequence with unlock cycles or, when the bypass mode input is high, through a short two-write sequence. The first accepted block opens a selection window. Each further confirm write during that window adds one more block to a list and starts the window again. When the window closes, the block hands the listed blocks one at a time to an external erase engine. It goes in ascending index order and passes over blocks whose protect bit is set.

While the sequencer is busy, or stuck in its error state, a bus read returns a status byte in place of the array data. Status bits not named below read 0. Bit 6 toggles on every read made while busy. Bit 5 shows an engine failure. Bit 3 is high while the selection window is open. If every selected block is protected, the sequencer stays busy for a fixed interval and then returns to read mode without starting the engine. An engine failure holds the error state until a reset command (F0h) is written.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy is 0, eng_start is 0 and bus_rdata equals array_rdata.
- R2: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h to any address select the block held in the top address bits (bus_addr[15:13] by default). Busy then rises, and a read returns status with bit 3 = 1 and bit 5 = 0.
- R3: A write that does not match the next expected cycle (data or, for unlock and setup cycles, the low 12 address bits) returns the machine to read mode with nothing selected.
- R4: With bypass_en = 1, the write 80h (any address) followed by 30h to a block address selects that block. With bypass_en = 0, that pair selects nothing.
- R5: While the window is open, a 30h write adds the addressed block and restarts the window. The engine is first started exactly SEL_CYC cycles after the last accepted selection. Selection writes made after the window closes are refused.
- R6: Selected blocks are passed to the engine one at a time, in ascending index order. The next start waits for eng_done.
- R7: Selected blocks whose blk_protect bit is set are never started. Skipping them sets no error bit.
- R8: If every selected block is protected, busy stays high and the engine is never started. Busy falls exactly SEL_CYC + ALLPROT_CYC cycles after the last selection.
- R9: Status bit 6 takes opposite values on two consecutive reads made while busy.
- R10: A write of F0h while the window is open drops the list and returns to read mode on the next cycle. F0h written while the engine runs has no effect.
- R11: If eng_fail is high with eng_done, the remaining blocks are still erased. Afterwards busy is 0, but reads return status with bit 5 = 1, and writes other than F0h leave it there. Writing F0h returns the machine to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data: array data or status byte |
| array_rdata | input | 8 | Data from the memory array |
| bypass_en | input | 1 | Short erase sequence allowed |
| blk_protect | input | NUM_BLOCKS | Per-block protect bits |
| eng_start | output | 1 | One-cycle start pulse to the erase engine |
| eng_blk | output | $clog2(NUM_BLOCKS) | Block index for the engine, valid with eng_start |
| eng_done | input | 1 | Engine finished the current block |
| eng_fail | input | 1 | Engine failure, sampled with eng_done |
| busy | output | 1 | Selection window open or erase running |

## Verification
The read path is combinational, so the bench samples bus_rdata one time step after driving the read strobe, before the edge that flips the toggle. Busy changes on the clock edge that takes the write. The first eng_start is due exactly SEL_CYC cycles after the edge of the last accepted selection. In the all-protected case, busy falls ALLPROT_CYC cycles after that. The bench stamps each write edge with a cycle counter and compares these differences exactly. Engine order and failures come from a bench engine model that answers each start three cycles later.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_SETUP, ST_U3, ST_U4,
    ST_BYP, ST_SEL, ST_RUN, ST_WAIT, ST_ALLP, ST_ERR
  } seq_state_t;

  localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B  = 8'h55;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [11:0] ADR_UNLK_A = 12'h555;
  localparam logic [11:0] ADR_UNLK_B = 12'h2AA;
endpackage

// File: rtl/fes_timer.sv
module fes_timer #(
  parameter int COUNT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en,
  output logic expired
);
  localparam int W = $clog2(COUNT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= W'(COUNT - 1);
    else if (en && cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = en && !load && (cnt == '0);

  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= W'(COUNT - 1));
endmodule

// File: rtl/fes_picker.sv
module fes_picker #(
  parameter int N = 8
) (
  input  logic [N-1:0]         vec,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);
  logic [N-1:0] first;

  assign first[0] = vec[0];
  generate
    for (genvar i = 1; i < N; i++) begin : g_first
      assign first[i] = vec[i] & ~(|vec[i-1:0]);
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int j = 0; j < N; j++)
      if (first[j]) idx = idx | IW'(j);
  end

  assign any = |vec;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int ADDR_W      = 16,
  parameter int SEL_CYC     = 12,
  parameter int ALLPROT_CYC = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [7:0]                    bus_wdata,
  input  logic                          bus_we,
  input  logic                          bus_re,
  output logic [7:0]                    bus_rdata,
  input  logic [7:0]                    array_rdata,
  input  logic                          bypass_en,
  input  logic [NUM_BLOCKS-1:0]         blk_protect,
  output logic                          eng_start,
  output logic [$clog2(NUM_BLOCKS)-1:0] eng_blk,
  input  logic                          eng_done,
  input  logic                          eng_fail,
  output logic                          busy
);
  localparam int BW = $clog2(NUM_BLOCKS);

  function automatic logic [BW-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BW];
  endfunction

  function automatic logic [NUM_BLOCKS-1:0] below_mask(input logic [BW-1:0] i);
    logic [NUM_BLOCKS-1:0] m;
    for (int j = 0; j < NUM_BLOCKS; j++) m[j] = (j < int'(i));
    return m;
  endfunction

  seq_state_t state, state_n;
  logic [NUM_BLOCKS-1:0] list, list_n;
  logic [BW-1:0] cur, cur_n;
  logic err, err_n, tog;

  // named internal events
  logic wr_unlk_a, wr_unlk_b, wr_setup_ok, wr_confirm, wr_reset;
  logic sel_load, sel_expired, allp_load, allp_expired;
  logic pick_any, all_protected, show_status, status_read;
  logic [BW-1:0] pick_idx;

  assign wr_unlk_a   = bus_we && bus_wdata == CMD_UNLK_A && bus_addr[11:0] == ADR_UNLK_A;
  assign wr_unlk_b   = bus_we && bus_wdata == CMD_UNLK_B && bus_addr[11:0] == ADR_UNLK_B;
  assign wr_setup_ok = bus_we && bus_wdata == CMD_SETUP  && bus_addr[11:0] == ADR_UNLK_A;
  assign wr_confirm  = bus_we && bus_wdata == CMD_CONFIRM;
  assign wr_reset    = bus_we && bus_wdata == CMD_RESET;

  fes_picker #(.N(NUM_BLOCKS)) u_pick (.vec(list), .any(pick_any), .idx(pick_idx));

  fes_timer #(.COUNT(SEL_CYC)) u_sel_tmr (
    .clk(clk), .rst_n(rst_n), .load(sel_load),
    .en(state == ST_SEL), .expired(sel_expired));

  fes_timer #(.COUNT(ALLPROT_CYC)) u_allp_tmr (
    .clk(clk), .rst_n(rst_n), .load(allp_load),
    .en(state == ST_ALLP), .expired(allp_expired));

  assign all_protected = (list & ~blk_protect) == '0;

  always_comb begin
    state_n   = state;
    list_n    = list;
    cur_n     = cur;
    err_n     = err;
    sel_load  = 1'b0;
    allp_load = 1'b0;
    eng_start = 1'b0;
    case (state)
      ST_READ:  if (bus_we) begin
                  if (wr_unlk_a) state_n = ST_U1;
                  else if (bypass_en && bus_wdata == CMD_SETUP) state_n = ST_BYP;
                end
      ST_U1:    if (bus_we) state_n = wr_unlk_b   ? ST_U2    : ST_READ;
      ST_U2:    if (bus_we) state_n = wr_setup_ok ? ST_SETUP : ST_READ;
      ST_SETUP: if (bus_we) state_n = wr_unlk_a   ? ST_U3    : ST_READ;
      ST_U3:    if (bus_we) state_n = wr_unlk_b   ? ST_U4    : ST_READ;
      ST_U4, ST_BYP:
        if (bus_we) begin
          if (wr_confirm) begin
            list_n[blk_of(bus_addr)] = 1'b1;
            sel_load = 1'b1;
            state_n  = ST_SEL;
          end else state_n = ST_READ;
        end
      ST_SEL:
        if (wr_reset) begin
          list_n  = '0;
          state_n = ST_READ;
        end else if (wr_confirm) begin
          list_n[blk_of(bus_addr)] = 1'b1;
          sel_load = 1'b1;
        end else if (sel_expired) begin
          if (all_protected) begin
            allp_load = 1'b1;
            state_n   = ST_ALLP;
          end else state_n = ST_RUN;
        end
      ST_RUN:
        if (!pick_any) state_n = err ? ST_ERR : ST_READ;
        else if (blk_protect[pick_idx]) list_n[pick_idx] = 1'b0;
        else begin
          eng_start = 1'b1;
          cur_n     = pick_idx;
          state_n   = ST_WAIT;
        end
      ST_WAIT:
        if (eng_done) begin
          list_n[cur] = 1'b0;
          err_n   = err | eng_fail;
          state_n = ST_RUN;
        end
      ST_ALLP:
        if (allp_expired) begin
          list_n  = '0;
          state_n = ST_READ;
        end
      ST_ERR:
        if (wr_reset) begin
          err_n   = 1'b0;
          state_n = ST_READ;
        end
      default: state_n = ST_READ;
    endcase
  end

  assign busy        = state inside {ST_SEL, ST_RUN, ST_WAIT, ST_ALLP};
  assign show_status = busy || state == ST_ERR;
  assign status_read = bus_re && busy;
  assign eng_blk     = pick_idx;
  assign bus_rdata   = show_status ? {1'b0, tog, err, 1'b0, state == ST_SEL, 3'b000}
                                   : array_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_READ;
      list  <= '0;
      cur   <= '0;
      err   <= 1'b0;
      tog   <= 1'b0;
    end else begin
      state <= state_n;
      list  <= list_n;
      cur   <= cur_n;
      err   <= err_n;
      if (status_read) tog <= ~tog;
    end
  end

  // R5: no block joins the list once the erase is under way
  a_r5_no_growth_running: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_RUN, ST_WAIT}) |=> ((list & ~$past(list)) == '0));
  // R6: a start only goes to the lowest pending block
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> ((list & below_mask(eng_blk)) == '0 && list[eng_blk]));
  // R6: no new start while the engine is working
  a_r6_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !eng_done) |=> !eng_start);
  // R7: protected blocks never reach the engine
  a_r7_no_protected_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !blk_protect[eng_blk]);
  // R9: toggle flips on every busy read
  a_r9_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    status_read |=> bus_rdata[6] != $past(bus_rdata[6]) || !show_status);
  // R11: error state holds until the reset command
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERR && !wr_reset) |=> state == ST_ERR);
  // R10: reset command ignored while the engine runs
  a_r10_run_ignores_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && wr_reset && !eng_done) |=> state == ST_WAIT);
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int NB = 8;
  localparam int SEL = 12;
  localparam int ALLP = 20;

  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, array_rdata = 8'hC3, bus_rdata;
  logic bus_we = 0, bus_re = 0, bypass_en = 0;
  logic [NB-1:0] blk_protect = '0, fail_mask = '0;
  logic eng_start, eng_done = 0, eng_fail = 0, busy;
  logic [2:0] eng_blk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int last_wr = 0, first_start = -1, nlog = 0, dly = 0;
  int log_blk [0:15];
  logic [2:0] eng_cur = '0;

  flash_erase_seq #(.NUM_BLOCKS(NB), .ADDR_W(16), .SEL_CYC(SEL), .ALLPROT_CYC(ALLP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .array_rdata(array_rdata),
    .bypass_en(bypass_en), .blk_protect(blk_protect), .eng_start(eng_start),
    .eng_blk(eng_blk), .eng_done(eng_done), .eng_fail(eng_fail), .busy(busy));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // engine model: answers each start three cycles later
  always @(negedge clk) begin
    if (eng_done) begin eng_done = 0; eng_fail = 0; end
    if (eng_start) begin
      if (first_start < 0) first_start = cyc;
      if (nlog < 16) log_blk[nlog] = int'(eng_blk);
      nlog = nlog + 1;
      eng_cur = eng_blk;
      dly = 3;
    end else if (dly > 0) begin
      dly = dly - 1;
      if (dly == 0) begin eng_done = 1; eng_fail = fail_mask[eng_cur]; end
    end
  end

  always @(posedge clk) if (cyc == 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s: act=%0d exp=%0d", what, act, exp); end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0; last_wr = cyc;
  endtask

  task automatic rd(output logic [7:0] v);
    bus_re = 1; #1; v = bus_rdata;
    @(negedge clk);
    bus_re = 0;
  endtask

  function automatic logic [15:0] ba(input int b);
    return 16'(b) << 13;
  endfunction

  task automatic std_seq(input int b);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(ba(b), 8'h30);
  endtask

  task automatic clear_log;
    nlog = 0; first_start = -1;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(eng_start == 0, "R1 eng_start", eng_start, 0);
    chk(bus_rdata == 8'hC3, "R1 array read", bus_rdata, 8'hC3);
  endtask

  task automatic t_standard;
    logic [7:0] s; int k;
    clear_log; std_seq(2); k = last_wr;
    chk(busy == 1, "R2 busy", busy, 1);
    rd(s);
    chk(s[3] == 1 && s[5] == 0, "R2 status window", s, 8'h08);
    wait_idle;
    chk(first_start - k == SEL, "R5 start delay", first_start - k, SEL);
    chk(nlog == 1 && log_blk[0] == 2, "R2 block erased", log_blk[0], 2);
    chk(bus_rdata == 8'hC3, "R2 back to read", bus_rdata, 8'hC3);
  endtask

  task automatic t_wrong;
    clear_log;
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0123, 8'h80);
    wr(ba(1), 8'h30);
    chk(busy == 0, "R3 wrong setup addr", busy, 0);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h54); wr(ba(1), 8'h30);
    repeat (SEL + 4) @(negedge clk);
    chk(busy == 0 && nlog == 0, "R3 wrong unlock data", nlog, 0);
  endtask

  task automatic t_bypass;
    clear_log; bypass_en = 0;
    wr(16'h0000, 8'h80); wr(ba(5), 8'h30);
    repeat (SEL + 4) @(negedge clk);
    chk(busy == 0 && nlog == 0, "R4 bypass off", nlog, 0);
    bypass_en = 1;
    wr(16'h0000, 8'h80); wr(ba(5), 8'h30); wr(ba(1), 8'h30);
    wait_idle;
    chk(nlog == 2 && log_blk[0] == 1 && log_blk[1] == 5, "R4 R6 bypass order",
        log_blk[0] * 10 + log_blk[1], 15);
    bypass_en = 0;
  endtask

  task automatic t_append;
    int k;
    clear_log; std_seq(6);
    repeat (5) @(negedge clk);
    wr(ba(3), 8'h30);
    repeat (5) @(negedge clk);
    wr(ba(0), 8'h30); k = last_wr;
    for (int i = 0; i < 100 && first_start < 0; i++) @(negedge clk);
    chk(first_start - k == SEL, "R5 window restart", first_start - k, SEL);
    wr(ba(7), 8'h30);
    wait_idle;
    chk(nlog == 3 && log_blk[0] == 0 && log_blk[1] == 3 && log_blk[2] == 6,
        "R6 ascending order", log_blk[0] * 100 + log_blk[1] * 10 + log_blk[2], 36);
    chk(nlog == 3, "R5 late select refused", nlog, 3);
  endtask

  task automatic t_protect;
    logic [7:0] s;
    clear_log; blk_protect = 8'h10;
    std_seq(4); wr(ba(2), 8'h30);
    wait_idle;
    chk(nlog == 1 && log_blk[0] == 2, "R7 protected skipped", nlog, 1);
    rd(s);
    chk(s == 8'hC3, "R7 no error", s, 8'hC3);
    blk_protect = '0;
  endtask

  task automatic t_allprot;
    int k, fell;
    clear_log; blk_protect = 8'h06;
    std_seq(1); wr(ba(2), 8'h30); k = last_wr;
    fell = -1;
    for (int i = 0; i < 200 && fell < 0; i++) begin
      if (!busy) fell = cyc;
      else @(negedge clk);
    end
    chk(fell - k == SEL + ALLP, "R8 busy interval", fell - k, SEL + ALLP);
    chk(nlog == 0, "R8 no engine start", nlog, 0);
    blk_protect = '0;
  endtask

  task automatic t_toggle;
    logic [7:0] a, b;
    clear_log; std_seq(0);
    rd(a); rd(b);
    chk(a[6] != b[6], "R9 toggle", b[6], !a[6]);
    wait_idle;
  endtask

  task automatic t_abort;
    clear_log; std_seq(3);
    wr(16'h0000, 8'hF0);
    chk(busy == 0, "R10 abort in window", busy, 0);
    repeat (SEL + 4) @(negedge clk);
    chk(nlog == 0, "R10 abort drops list", nlog, 0);
    std_seq(3); wr(ba(4), 8'h30);
    for (int i = 0; i < 100 && first_start < 0; i++) @(negedge clk);
    wr(16'h0000, 8'hF0);
    chk(busy == 1, "R10 reset ignored while running", busy, 1);
    wait_idle;
    chk(nlog == 2, "R10 run completes", nlog, 2);
  endtask

  task automatic t_fail;
    logic [7:0] s;
    clear_log; fail_mask = 8'h04;
    std_seq(5); wr(ba(2), 8'h30);
    wait_idle;
    chk(nlog == 2 && log_blk[0] == 2 && log_blk[1] == 5, "R11 rest erased", nlog, 2);
    rd(s);
    chk(busy == 0 && s[5] == 1, "R11 error status", s, 8'h20);
    wr(16'h0555, 8'hAA);
    rd(s);
    chk(s[5] == 1, "R11 error held", s, 8'h20);
    wr(16'h0000, 8'hF0);
    rd(s);
    chk(s == 8'hC3, "R11 cleared by F0", s, 8'hC3);
    fail_mask = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_standard;
    t_wrong;
    t_bypass;
    t_append;
    t_protect;
    t_allprot;
    t_toggle;
    t_abort;
    t_fail;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule